// File: doc/BRIEF.md
# Pipelined Per-Queue Delay Dropper

This block decides, one packet per clock, whether a packet leaving a queue should be discarded to keep queueing delay under control. Each cycle it may take a descriptor carrying a queue number, the delay that packet spent queued, the current queue occupancy in bytes and a timestamp. Four cycles later it presents the same descriptor together with a drop mark. Downstream logic discards the packet when the mark is set.

The decision follows a controlled-delay law. A queue enters a dropping state on the first packet whose delay is too high while the queue holds at least one maximum-sized packet. That first packet is never dropped. Instead, a drop deadline is armed one interval ahead. While the violation persists, each packet at or after the deadline is dropped. The drop count is then raised and the next deadline is placed closer. A single non-violating packet returns the queue to the not-dropping state.

The work is split across four stages:

- The first stage is stateless.
- The second stage holds only the per-queue dropping flag.
- The third stage holds the per-queue count and deadline as one atomic unit.
- The fourth stage combines the results into the drop mark.

No stage feeds anything back to an earlier one. Each stateful stage reads and writes its own registers in the same cycle, so back-to-back packets to the same queue need no forwarding.

Top module: `aqm_drop_pipe`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` and `out_drop` are 0 and every queue starts in the not-dropping state with a zero count.
- R2: A descriptor presented with `in_valid`=1 appears on the outputs exactly four clock edges later with `out_valid`=1 and its queue, delay, bytes and time fields unchanged.
- R3: A packet violates when `in_delay` >= TARGET and `in_bytes` >= MTU. A non-violating packet is never dropped and returns its queue to the not-dropping state.
- R4: The first violating packet of a queue in the not-dropping state is not dropped. It sets the queue to dropping, its count to 1 and its deadline to time + INTERVAL.
- R5: A violating packet of a dropping queue whose time is at or after the deadline is dropped. The count becomes count+1, saturating at all ones. The new deadline is time + (INTERVAL >> (m/2)), where m is the index of the most significant set bit of the new count. Times are compared modulo 2^TIME_W as a signed difference.
- R6: A violating packet of a dropping queue whose time is before the deadline is not dropped and changes no state.
- R7: State is kept separately per queue; packets of one queue never change the drop decisions of another queue.
- R8: On re-entering the dropping state after having left it, the count restarts at 1 and the deadline at time + INTERVAL, whatever the earlier count was.
- R9: Consecutive packets to the same queue on consecutive clocks each see the state left by the one before.
- R10: A cycle with `in_valid`=0 changes no state and yields `out_valid`=0 and `out_drop`=0 four edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor present this cycle |
| in_queue | input | Q_W | Queue number |
| in_delay | input | DELAY_W | Queueing delay of the packet |
| in_bytes | input | BYTES_W | Queue occupancy in bytes |
| in_time | input | TIME_W | Current timestamp |
| out_valid | output | 1 | Descriptor present on the outputs |
| out_queue | output | Q_W | Queue number, delayed |
| out_delay | output | DELAY_W | Delay, delayed |
| out_bytes | output | BYTES_W | Bytes, delayed |
| out_time | output | TIME_W | Timestamp, delayed |
| out_drop | output | 1 | Packet is to be discarded |

## Verification
The hardest situation to reach is a long dropping episode on one queue. Such an episode pushes the count past the points where the deadline spacing shrinks. It also has a deadline landing exactly on a packet timestamp and a drop in the cycle right after the queue was armed.

The stimulus drives streams of back-to-back violating packets to a single queue with a fixed time step, so deadlines are crossed many times in a row. Other streams interleave queues with opposite violation patterns. Queues are made to leave and re-enter the dropping state. Threshold values sit at one below and exactly on the limits. A long random phase then mixes all queues, idle slots and delays around the target. The bench model tracks every queue independently and compares every output on every clock.

// File: rtl/aqm_pkg.sv
package aqm_pkg;

   // index of most significant set bit, 0 for an input of 0 or 1
   function automatic int unsigned top_bit(input logic [31:0] v);
      int unsigned r;
      r = 0;
      for (int i = 0; i < 32; i++) begin
         if (v[i]) r = i;
      end
      return r;
   endfunction

endpackage

// File: rtl/aqm_viol_stage.sv
module aqm_viol_stage #(
   parameter int DELAY_W = 16,
   parameter int BYTES_W = 16,
   parameter int TARGET  = 50,
   parameter int MTU     = 1500
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid_i,
   input  logic [DELAY_W-1:0] delay_i,
   input  logic [BYTES_W-1:0] bytes_i,
   output logic               viol_q
);
   localparam logic [DELAY_W-1:0] TGT = DELAY_W'(TARGET);
   localparam logic [BYTES_W-1:0] LIM = BYTES_W'(MTU);

   always_ff @(posedge clk) begin
      if (!rst_n) viol_q <= 1'b0;
      else        viol_q <= valid_i && (delay_i >= TGT) && (bytes_i >= LIM);
   end
endmodule

// File: rtl/aqm_flag_stage.sv
module aqm_flag_stage #(
   parameter int NQ  = 8,
   parameter int Q_W = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           valid_i,
   input  logic [Q_W-1:0] queue_i,
   input  logic           viol_i,
   output logic           first_q
);
   logic [NQ-1:0] flag_r;
   logic          cur;

   assign cur = flag_r[queue_i];

   for (genvar g = 0; g < NQ; g++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)                                      flag_r[g] <= 1'b0;
         else if (valid_i && queue_i == Q_W'(g))          flag_r[g] <= viol_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) first_q <= 1'b0;
      else        first_q <= valid_i && viol_i && !cur;
   end

   // a first-violation pulse needs a valid violating packet one cycle before
   assert_first_has_viol_R4: assert property (@(posedge clk) disable iff (!rst_n)
      first_q |-> $past(valid_i && viol_i));
endmodule

// File: rtl/aqm_sched_stage.sv
module aqm_sched_stage
   import aqm_pkg::*;
#(
   parameter int NQ       = 8,
   parameter int Q_W      = 3,
   parameter int TIME_W   = 32,
   parameter int CNT_W    = 16,
   parameter int INTERVAL = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [Q_W-1:0]    queue_i,
   input  logic [TIME_W-1:0] time_i,
   input  logic              viol_i,
   input  logic              first_i,
   output logic              cand_q
);
   localparam logic [TIME_W-1:0] IVL    = TIME_W'(INTERVAL);
   localparam logic [CNT_W-1:0]  CNT_MX = {CNT_W{1'b1}};

   logic [CNT_W-1:0]  cnt_r  [NQ];
   logic [TIME_W-1:0] next_r [NQ];

   logic [CNT_W-1:0]  cur_cnt, inc_cnt, new_cnt;
   logic [TIME_W-1:0] cur_next, diff, new_next;
   logic              due, wr, cand_d;
   int unsigned       shamt;

   always_comb begin
      cur_cnt  = cnt_r[queue_i];
      cur_next = next_r[queue_i];
      diff     = time_i - cur_next;
      due      = !diff[TIME_W-1];
      inc_cnt  = (cur_cnt == CNT_MX) ? cur_cnt : cur_cnt + 1'b1;
      shamt    = top_bit(32'(inc_cnt)) >> 1;
      wr       = 1'b0;
      cand_d   = 1'b0;
      new_cnt  = cur_cnt;
      new_next = cur_next;
      if (valid_i && first_i) begin
         wr       = 1'b1;
         new_cnt  = CNT_W'(1);
         new_next = time_i + IVL;
      end else if (valid_i && viol_i && due) begin
         wr       = 1'b1;
         cand_d   = 1'b1;
         new_cnt  = inc_cnt;
         new_next = time_i + (IVL >> shamt);
      end
   end

   for (genvar g = 0; g < NQ; g++) begin : g_unit
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_r[g]  <= '0;
            next_r[g] <= '0;
         end else if (wr && queue_i == Q_W'(g)) begin
            cnt_r[g]  <= new_cnt;
            next_r[g] <= new_next;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cand_q <= 1'b0;
      else        cand_q <= cand_d;
   end

   // a candidate drop only comes from an already-dropping violating packet
   assert_cand_only_dropping_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cand_q |-> $past(valid_i && viol_i && !first_i));
endmodule

// File: rtl/aqm_drop_pipe.sv
module aqm_drop_pipe #(
   parameter int NQ       = 8,
   parameter int Q_W      = (NQ > 1) ? $clog2(NQ) : 1,
   parameter int DELAY_W  = 16,
   parameter int BYTES_W  = 16,
   parameter int TIME_W   = 32,
   parameter int CNT_W    = 16,
   parameter int TARGET   = 50,
   parameter int MTU      = 1500,
   parameter int INTERVAL = 1000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [Q_W-1:0]     in_queue,
   input  logic [DELAY_W-1:0] in_delay,
   input  logic [BYTES_W-1:0] in_bytes,
   input  logic [TIME_W-1:0]  in_time,
   output logic               out_valid,
   output logic [Q_W-1:0]     out_queue,
   output logic [DELAY_W-1:0] out_delay,
   output logic [BYTES_W-1:0] out_bytes,
   output logic [TIME_W-1:0]  out_time,
   output logic               out_drop
);
   localparam int DEPTH = 4;
   localparam int DW    = Q_W + DELAY_W + BYTES_W + TIME_W;

   initial begin
      assert (NQ >= 2 && NQ <= (1 << Q_W)) else $error("NQ does not fit Q_W");
      assert (INTERVAL > 0 && TIME_W > $clog2(INTERVAL) + 1) else $error("INTERVAL too wide");
      assert (CNT_W >= 2 && CNT_W <= 32) else $error("CNT_W out of range");
   end

   logic [DW-1:0] data_p  [DEPTH];
   logic          valid_p [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_pipe
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_p[s] <= 1'b0;
            data_p[s]  <= '0;
         end else if (s == 0) begin
            valid_p[s] <= in_valid;
            data_p[s]  <= {in_queue, in_delay, in_bytes, in_time};
         end else begin
            valid_p[s] <= valid_p[s-1];
            data_p[s]  <= data_p[s-1];
         end
      end
   end

   logic [Q_W-1:0]    q0, q1;
   logic [TIME_W-1:0] t1;
   assign q0 = data_p[0][DW-1 -: Q_W];
   assign q1 = data_p[1][DW-1 -: Q_W];
   assign t1 = data_p[1][TIME_W-1:0];

   logic viol_s1, viol_s2, viol_s3, first_s2, cand_s3;

   aqm_viol_stage #(.DELAY_W(DELAY_W), .BYTES_W(BYTES_W), .TARGET(TARGET), .MTU(MTU))
   u_viol (.clk(clk), .rst_n(rst_n), .valid_i(in_valid), .delay_i(in_delay),
           .bytes_i(in_bytes), .viol_q(viol_s1));

   aqm_flag_stage #(.NQ(NQ), .Q_W(Q_W))
   u_flag (.clk(clk), .rst_n(rst_n), .valid_i(valid_p[0]), .queue_i(q0),
           .viol_i(viol_s1), .first_q(first_s2));

   aqm_sched_stage #(.NQ(NQ), .Q_W(Q_W), .TIME_W(TIME_W), .CNT_W(CNT_W), .INTERVAL(INTERVAL))
   u_sched (.clk(clk), .rst_n(rst_n), .valid_i(valid_p[1]), .queue_i(q1), .time_i(t1),
            .viol_i(viol_s2), .first_i(first_s2), .cand_q(cand_s3));

   // violation bit travels alongside the descriptor
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         viol_s2  <= 1'b0;
         viol_s3  <= 1'b0;
         out_drop <= 1'b0;
      end else begin
         viol_s2  <= viol_s1;
         viol_s3  <= viol_s2;
         out_drop <= valid_p[2] && viol_s3 && cand_s3;
      end
   end

   assign out_valid = valid_p[DEPTH-1];
   assign {out_queue, out_delay, out_bytes, out_time} = data_p[DEPTH-1];

   // checker: cycles since reset, saturating at the pipeline depth
   logic [2:0] since_rst;
   always_ff @(posedge clk) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
   end

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

   assert_queue_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 3'd4 && out_valid) |-> (out_queue == $past(in_queue, 4)));

   assert_drop_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_drop |-> out_valid);
endmodule

// File: tb/aqm_drop_pipe_bench.sv
module aqm_drop_pipe_bench;
   localparam int NQ = 8, QW = 3, TARGET = 50, MTU = 1500, INTERVAL = 1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_queue = '0;
   logic [15:0] in_delay = '0, in_bytes = '0;
   logic [31:0] in_time = '0;
   logic        out_valid, out_drop;
   logic [2:0]  out_queue;
   logic [15:0] out_delay, out_bytes;
   logic [31:0] out_time;

   always #4 clk = ~clk;

   aqm_drop_pipe u_aqm_drop_pipe (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_queue(in_queue),
      .in_delay(in_delay), .in_bytes(in_bytes), .in_time(in_time),
      .out_valid(out_valid), .out_queue(out_queue), .out_delay(out_delay),
      .out_bytes(out_bytes), .out_time(out_time), .out_drop(out_drop));

   int vectors = 0, errors = 0;

   // behavioural model state per queue
   bit          m_drop [NQ];
   bit          m_seen [NQ];
   int unsigned m_cnt  [NQ];
   logic [31:0] m_next [NQ];
   logic [31:0] now = 32'd10;

   // expected outputs, four-slot delay line
   bit          e_v [4];
   bit          e_d [4];
   logic [2:0]  e_q [4];
   logic [15:0] e_dl [4], e_b [4];
   logic [31:0] e_t [4];
   string       e_tag [4];

   function automatic int unsigned msb_of(int unsigned v);
      int unsigned r = 0;
      while (v > 1) begin v = v / 2; r++; end
      return r;
   endfunction

   task automatic model(input logic [2:0] q, input logic [15:0] d, input logic [15:0] b,
                        input logic [31:0] t, output bit drop, output string tag);
      logic [31:0] df;
      drop = 0;
      if (!(d >= TARGET && b >= MTU)) begin
         m_drop[q] = 0; tag = "R3";
      end else if (!m_drop[q]) begin
         tag = m_seen[q] ? "R8" : "R4";
         m_drop[q] = 1; m_seen[q] = 1; m_cnt[q] = 1; m_next[q] = t + INTERVAL;
      end else begin
         df = t - m_next[q];
         if (!df[31]) begin
            drop = 1; tag = "R5";
            if (m_cnt[q] < 65535) m_cnt[q]++;
            m_next[q] = t + (INTERVAL >> (msb_of(m_cnt[q]) / 2));
         end else tag = "R6";
      end
   endtask

   task automatic compare();
      vectors++;
      if (out_valid !== e_v[3]) begin
         errors++;
         $display("FAIL %s out_valid actual=%0b expected=%0b", e_v[3] ? "R2" : "R10", out_valid, e_v[3]);
      end else if (e_v[3]) begin
         if (out_queue !== e_q[3] || out_delay !== e_dl[3] || out_bytes !== e_b[3] || out_time !== e_t[3]) begin
            errors++;
            $display("FAIL R2 fields actual=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
                     out_queue, out_delay, out_bytes, out_time, e_q[3], e_dl[3], e_b[3], e_t[3]);
         end
         if (out_drop !== e_d[3]) begin
            errors++;
            $display("FAIL %s drop q=%0d t=%0d actual=%0b expected=%0b", e_tag[3], e_q[3], e_t[3], out_drop, e_d[3]);
         end
      end else if (out_drop !== 1'b0) begin
         errors++;
         $display("FAIL R10 drop on empty slot actual=%0b expected=0", out_drop);
      end
   endtask

   // one clock: check, shift, drive the next descriptor
   task automatic apply(input bit v, input int q, input int d, input int b, input int step);
      bit dr; string tg;
      @(negedge clk);
      compare();
      for (int i = 3; i > 0; i--) begin
         e_v[i] = e_v[i-1]; e_d[i] = e_d[i-1]; e_q[i] = e_q[i-1];
         e_dl[i] = e_dl[i-1]; e_b[i] = e_b[i-1]; e_t[i] = e_t[i-1]; e_tag[i] = e_tag[i-1];
      end
      now = now + 32'(step);
      in_valid = v; in_queue = 3'(q); in_delay = 16'(d); in_bytes = 16'(b); in_time = now;
      dr = 0; tg = "R10";
      if (v) model(3'(q), 16'(d), 16'(b), now, dr, tg);
      e_v[0] = v; e_d[0] = dr; e_q[0] = 3'(q); e_dl[0] = 16'(d); e_b[0] = 16'(b);
      e_t[0] = now; e_tag[0] = tg;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin : stim
      for (int i = 0; i < 4; i++) begin e_v[i] = 0; e_d[i] = 0; e_tag[i] = "R1"; end
      for (int i = 0; i < NQ; i++) begin m_drop[i] = 0; m_seen[i] = 0; m_cnt[i] = 0; m_next[i] = 0; end
      // R1: outputs idle during reset
      repeat (3) begin
         @(negedge clk);
         vectors++;
         if (out_valid !== 1'b0 || out_drop !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs actual=%0b%0b expected=00", out_valid, out_drop);
         end
         in_valid = 1'b1; in_delay = 16'd900; in_bytes = 16'd9000;
      end
      @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;
      // R1 after release: a violating packet is the first one, never dropped
      apply(1, 5, 200, 3000, 7);
      // R5 R9: long back-to-back violating stream to one queue
      for (int i = 0; i < 120; i++) apply(1, 0, 120, 2000, 150);
      // exact deadline hit: step equal to INTERVAL
      for (int i = 0; i < 6; i++) apply(1, 3, 60, 1600, INTERVAL);
      // R7: queue 1 violates while queue 2 stays below target
      for (int i = 0; i < 60; i++) begin
         apply(1, 1, 80, 1800, 90);
         apply(1, 2, 10, 5000, 90);
      end
      // R8: queue 0 leaves the dropping state and re-enters
      apply(1, 0, 20, 2000, 40);
      for (int i = 0; i < 30; i++) apply(1, 0, 120, 2000, 200);
      // R10: idle slots carrying violating fields change nothing
      for (int i = 0; i < 10; i++) apply(0, 0, 900, 9000, 500);
      apply(1, 0, 120, 2000, 1);
      // R3 boundaries: one below and exactly at each limit
      apply(1, 4, TARGET - 1, 4000, 10);
      apply(1, 4, 4000, MTU - 1, 10);
      apply(1, 4, TARGET, MTU, 10);
      apply(1, 4, TARGET, MTU, INTERVAL);
      apply(1, 4, TARGET - 1, MTU, 10);
      // mixed random traffic over all queues
      for (int i = 0; i < 4000; i++)
         apply(($urandom % 5) != 0, $urandom % NQ, 20 + ($urandom % 70),
               1300 + ($urandom % 400), $urandom % 120);
      for (int i = 0; i < 5; i++) apply(0, 0, 0, 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule